// File: doc/BRIEF.md
# Cluster Private Window Address Decoder

This block sits between one bus requester and the private peripherals of a multi-core cluster. It owns an 8 KB window. For each request it picks exactly one target: the coherency-control register block, one core's interrupt CPU interface, one core's timer, one core's watchdog, or the interrupt distributor. It hands that target the request's offset relative to the target's own base, along with the write flag and write data. One cycle later it returns that target's read data as a response. An address that lands in no mapped slot selects nothing and returns a zeroed response with an error flag.

Two slots in the window are aliases. The first interface slot and the first timer/watchdog slot reach the interface or timer of whichever core issued the request, as named by the requester's core-ID input. The slots after each alias address physical cores 0, 1, 2 in 0x100 steps.

The block also wires the interrupt outputs of the per-core timers and watchdogs onto fixed private interrupt numbers of each core. It places these above the external interrupt lines on a flat line vector that feeds the interrupt controller.

Top module: `priv_win_top`

## Requirements
- R1: Offsets 0x000 to 0x0FF select only the coherency-control block, with target offset equal to address bits [7:0].
- R2: Offset 0x100 to 0x1FF selects the interrupt CPU interface of the core named on `req_core`. Offsets 0x200+0x100*n to 0x2FF+0x100*n select the interface of core n. The target offset is address bits [7:0].
- R3: The slot at 0x600 selects the timer of the core named on `req_core`, and the slot at 0x700+0x100*n selects the timer of core n. Within a slot the timer occupies bytes 0x00 to 0x1F, and the target offset is address bits [4:0].
- R4: Each watchdog occupies bytes 0x20 to 0x3F of the same slot as its timer (0x620 for the requesting core, 0x720+0x100*n for core n), with target offset equal to address bits [4:0].
- R5: Offsets 0x1000 to 0x1FFF select the interrupt distributor, with target offset equal to address bits [11:0].
- R6: An unmapped address selects no target and yields a response with `rsp_err`=1 and `rsp_rdata`=0. Unmapped addresses are: bytes 0x40 to 0xFF of a timer slot, offsets 0xB00 to 0xFFF, and any slot or alias that names a core index at or above NUM_CORES.
- R7: A request accepted on a rising edge drives its select, `tgt_offset`, `tgt_write` and `tgt_wdata` for the following cycle. The response follows one cycle later, and back-to-back requests are allowed.
- R8: `irq_lines` bits [IRQ_TOTAL-33:0] copy `ext_irq`. Bit (IRQ_TOTAL-32)+32*n+29 copies `tmr_irq[n]` and bit (IRQ_TOTAL-32)+32*n+30 copies `wdg_irq[n]`. All other bits are 0.
- R9: While `rst_n` is low, no select and no `rsp_valid` is driven.
- R10: At most one target select is high in any cycle.
- R11: A mapped read returns the selected target's read data. A write response returns 0 read data with `rsp_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte offset inside the window |
| req_wdata | input | DATA_W | Write data |
| req_core | input | 2 | Core index of the requester, used for alias slots |
| ctl_sel | output | 1 | Coherency-control block select |
| cpuif_sel | output | NUM_CORES | Per-core interrupt CPU interface select |
| tmr_sel | output | NUM_CORES | Per-core timer select |
| wdg_sel | output | NUM_CORES | Per-core watchdog select |
| dist_sel | output | 1 | Interrupt distributor select |
| tgt_write | output | 1 | Write flag toward targets |
| tgt_offset | output | 12 | Offset relative to the selected target |
| tgt_wdata | output | DATA_W | Write data toward targets |
| ctl_rdata | input | DATA_W | Read data of the coherency-control block |
| cpuif_rdata | input | NUM_CORES*DATA_W | Read data of each CPU interface, core n at [n*DATA_W +: DATA_W] |
| tmr_rdata | input | NUM_CORES*DATA_W | Read data of each timer |
| wdg_rdata | input | NUM_CORES*DATA_W | Read data of each watchdog |
| dist_rdata | input | DATA_W | Read data of the distributor |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Response is for an unmapped address |
| rsp_rdata | output | DATA_W | Response read data |
| ext_irq | input | IRQ_TOTAL-32 | External interrupt lines |
| tmr_irq | input | NUM_CORES | Per-core timer interrupt |
| wdg_irq | input | NUM_CORES | Per-core watchdog interrupt |
| irq_lines | output | IRQ_TOTAL-32+32*NUM_CORES | Flat interrupt vector toward the controller |

## Verification
The state of the block is one pipeline register set. It holds the decoded target kind, the core index, the offset and the pending response. A wrong kind or index shows at the ports in the very next cycle as the wrong select line. That cycle's read data then comes from the wrong model, so the response one cycle later carries a value whose upper bits name the wrong target. A lost or duplicated valid bit shows as a missing or extra response two cycles after the request, and the scoreboard queue then goes out of step.

// File: rtl/priv_win_pkg.sv
package priv_win_pkg;
    localparam int WIN_AW       = 13;
    localparam int TGT_OW       = 12;
    localparam int CORE_W       = 2;
    localparam int MAX_CORES    = 4;
    localparam int PPI_PER_CORE = 32;
    localparam int PPI_TIMER    = 29;
    localparam int PPI_WDOG     = 30;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CTL,
        TGT_CPUIF,
        TGT_TMR,
        TGT_WDG,
        TGT_DIST
    } tgt_e;

    typedef struct packed {
        tgt_e                kind;
        logic [CORE_W-1:0]   core;
        logic [TGT_OW-1:0]   off;
        logic                err;
    } dec_t;
endpackage

// File: rtl/priv_win_decode.sv
module priv_win_decode
    import priv_win_pkg::*;
#(
    parameter int NUM_CORES = 3
) (
    input  logic [WIN_AW-1:0] addr,
    input  logic [CORE_W-1:0] cur_core,
    output dec_t              dec
);
    localparam logic [3:0] CORE_LIM = 4'(NUM_CORES);

    logic [3:0]        slot;
    logic [2:0]        sub;
    logic [3:0]        idx;
    logic [TGT_OW-1:0] off;
    tgt_e              kind;
    logic              miss;

    always_comb begin
        slot = addr[11:8];
        sub  = addr[7:5];
        idx  = 4'd0;
        off  = '0;
        kind = TGT_NONE;
        miss = 1'b0;
        if (addr[12]) begin
            kind = TGT_DIST;
            off  = addr[11:0];
        end else if (slot == 4'd0) begin
            kind = TGT_CTL;
            off  = {4'd0, addr[7:0]};
        end else if (slot <= 4'd5) begin
            kind = TGT_CPUIF;
            idx  = (slot == 4'd1) ? {2'd0, cur_core} : slot - 4'd2;
            off  = {4'd0, addr[7:0]};
        end else if (slot <= 4'd10) begin
            idx = (slot == 4'd6) ? {2'd0, cur_core} : slot - 4'd7;
            off = {7'd0, addr[4:0]};
            if (sub == 3'd0)      kind = TGT_TMR;
            else if (sub == 3'd1) kind = TGT_WDG;
            else                  miss = 1'b1;
        end else begin
            miss = 1'b1;
        end
        if ((kind == TGT_CPUIF || kind == TGT_TMR || kind == TGT_WDG) && idx >= CORE_LIM)
            miss = 1'b1;
        dec.kind = miss ? TGT_NONE : kind;
        dec.core = idx[CORE_W-1:0];
        dec.off  = off;
        dec.err  = miss;
    end
endmodule

// File: rtl/priv_irq_route.sv
module priv_irq_route
    import priv_win_pkg::*;
#(
    parameter int NUM_CORES = 3,
    parameter int IRQ_TOTAL = 64
) (
    input  logic [IRQ_TOTAL-33:0]                        ext_irq,
    input  logic [NUM_CORES-1:0]                         tmr_irq,
    input  logic [NUM_CORES-1:0]                         wdg_irq,
    output logic [IRQ_TOTAL-32+PPI_PER_CORE*NUM_CORES-1:0] irq_lines
);
    localparam int EXT_N = IRQ_TOTAL - 32;

    assign irq_lines[EXT_N-1:0] = ext_irq;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        localparam int BASE = EXT_N + c * PPI_PER_CORE;
        for (genvar b = 0; b < PPI_PER_CORE; b++) begin : g_bit
            if (b == PPI_TIMER) begin : g_t
                assign irq_lines[BASE+b] = tmr_irq[c];
            end else if (b == PPI_WDOG) begin : g_w
                assign irq_lines[BASE+b] = wdg_irq[c];
            end else begin : g_z
                assign irq_lines[BASE+b] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/priv_win_top.sv
module priv_win_top
    import priv_win_pkg::*;
#(
    parameter int NUM_CORES = 3,
    parameter int IRQ_TOTAL = 64,
    parameter int DATA_W    = 32
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          req_valid,
    input  logic                                          req_write,
    input  logic [WIN_AW-1:0]                             req_addr,
    input  logic [DATA_W-1:0]                             req_wdata,
    input  logic [CORE_W-1:0]                             req_core,
    output logic                                          ctl_sel,
    output logic [NUM_CORES-1:0]                          cpuif_sel,
    output logic [NUM_CORES-1:0]                          tmr_sel,
    output logic [NUM_CORES-1:0]                          wdg_sel,
    output logic                                          dist_sel,
    output logic                                          tgt_write,
    output logic [TGT_OW-1:0]                             tgt_offset,
    output logic [DATA_W-1:0]                             tgt_wdata,
    input  logic [DATA_W-1:0]                             ctl_rdata,
    input  logic [NUM_CORES*DATA_W-1:0]                   cpuif_rdata,
    input  logic [NUM_CORES*DATA_W-1:0]                   tmr_rdata,
    input  logic [NUM_CORES*DATA_W-1:0]                   wdg_rdata,
    input  logic [DATA_W-1:0]                             dist_rdata,
    output logic                                          rsp_valid,
    output logic                                          rsp_err,
    output logic [DATA_W-1:0]                             rsp_rdata,
    input  logic [IRQ_TOTAL-33:0]                         ext_irq,
    input  logic [NUM_CORES-1:0]                          tmr_irq,
    input  logic [NUM_CORES-1:0]                          wdg_irq,
    output logic [IRQ_TOTAL-32+PPI_PER_CORE*NUM_CORES-1:0] irq_lines
);
    typedef struct packed {
        logic                s_vld;
        logic                s_wr;
        tgt_e                s_kind;
        logic [CORE_W-1:0]   s_core;
        logic [TGT_OW-1:0]   s_off;
        logic [DATA_W-1:0]   s_wd;
        logic                s_err;
        logic                r_vld;
        logic                r_err;
        logic [DATA_W-1:0]   r_rd;
    } st_t;

    st_t  st_d, st_q;
    dec_t dec;

    logic [DATA_W-1:0] cpuif_arr [MAX_CORES];
    logic [DATA_W-1:0] tmr_arr   [MAX_CORES];
    logic [DATA_W-1:0] wdg_arr   [MAX_CORES];
    logic [DATA_W-1:0] sel_rd;

    priv_win_decode #(.NUM_CORES(NUM_CORES)) u_dec (
        .addr     (req_addr),
        .cur_core (req_core),
        .dec      (dec)
    );

    priv_irq_route #(.NUM_CORES(NUM_CORES), .IRQ_TOTAL(IRQ_TOTAL)) u_irq (
        .ext_irq   (ext_irq),
        .tmr_irq   (tmr_irq),
        .wdg_irq   (wdg_irq),
        .irq_lines (irq_lines)
    );

    for (genvar c = 0; c < MAX_CORES; c++) begin : g_slot
        if (c < NUM_CORES) begin : g_live
            assign cpuif_arr[c] = cpuif_rdata[c*DATA_W +: DATA_W];
            assign tmr_arr[c]   = tmr_rdata[c*DATA_W +: DATA_W];
            assign wdg_arr[c]   = wdg_rdata[c*DATA_W +: DATA_W];
            assign cpuif_sel[c] = st_q.s_vld && st_q.s_kind == TGT_CPUIF && st_q.s_core == CORE_W'(c);
            assign tmr_sel[c]   = st_q.s_vld && st_q.s_kind == TGT_TMR   && st_q.s_core == CORE_W'(c);
            assign wdg_sel[c]   = st_q.s_vld && st_q.s_kind == TGT_WDG   && st_q.s_core == CORE_W'(c);
        end else begin : g_pad
            assign cpuif_arr[c] = '0;
            assign tmr_arr[c]   = '0;
            assign wdg_arr[c]   = '0;
        end
    end

    assign ctl_sel    = st_q.s_vld && st_q.s_kind == TGT_CTL;
    assign dist_sel   = st_q.s_vld && st_q.s_kind == TGT_DIST;
    assign tgt_write  = st_q.s_wr;
    assign tgt_offset = st_q.s_off;
    assign tgt_wdata  = st_q.s_wd;
    assign rsp_valid  = st_q.r_vld;
    assign rsp_err    = st_q.r_err;
    assign rsp_rdata  = st_q.r_rd;

    always_comb begin
        case (st_q.s_kind)
            TGT_CTL:   sel_rd = ctl_rdata;
            TGT_CPUIF: sel_rd = cpuif_arr[st_q.s_core];
            TGT_TMR:   sel_rd = tmr_arr[st_q.s_core];
            TGT_WDG:   sel_rd = wdg_arr[st_q.s_core];
            TGT_DIST:  sel_rd = dist_rdata;
            default:   sel_rd = '0;
        endcase
    end

    always_comb begin
        st_d        = st_q;
        st_d.s_vld  = req_valid;
        st_d.s_wr   = req_valid && req_write;
        st_d.s_kind = req_valid ? dec.kind : TGT_NONE;
        st_d.s_core = dec.core;
        st_d.s_off  = dec.off;
        st_d.s_wd   = req_wdata;
        st_d.s_err  = req_valid && dec.err;
        st_d.r_vld  = st_q.s_vld;
        st_d.r_err  = st_q.s_vld && st_q.s_err;
        st_d.r_rd   = (!st_q.s_vld || st_q.s_wr || st_q.s_err) ? '0 : sel_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/priv_win_chk.sv
module priv_win_chk
    import priv_win_pkg::*;
#(
    parameter int NUM_CORES = 3,
    parameter int IRQ_TOTAL = 64,
    parameter int DATA_W    = 32
) (
    input logic                                          clk,
    input logic                                          rst_n,
    input logic                                          req_valid,
    input logic                                          ctl_sel,
    input logic [NUM_CORES-1:0]                          cpuif_sel,
    input logic [NUM_CORES-1:0]                          tmr_sel,
    input logic [NUM_CORES-1:0]                          wdg_sel,
    input logic                                          dist_sel,
    input logic                                          rsp_valid,
    input logic                                          rsp_err,
    input logic [DATA_W-1:0]                             rsp_rdata,
    input logic [IRQ_TOTAL-33:0]                         ext_irq,
    input logic [NUM_CORES-1:0]                          tmr_irq,
    input logic [NUM_CORES-1:0]                          wdg_irq,
    input logic [IRQ_TOTAL-32+PPI_PER_CORE*NUM_CORES-1:0] irq_lines
);
    localparam int EXT_N = IRQ_TOTAL - 32;

    logic any_sel;
    assign any_sel = ctl_sel | dist_sel | (|cpuif_sel) | (|tmr_sel) | (|wdg_sel);

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl_sel, cpuif_sel, tmr_sel, wdg_sel, dist_sel})); // R10

    AST_SEL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        any_sel |-> $past(req_valid)); // R7

    AST_SEL_THEN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        any_sel |=> (rsp_valid && !rsp_err)); // R7

    AST_REQ_THEN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ##2 rsp_valid); // R7

    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0)); // R6

    AST_ERR_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> !$past(any_sel)); // R6

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!rsp_valid && !any_sel)); // R9

    AST_IRQ_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_lines) == $countones(ext_irq) + $countones(tmr_irq) + $countones(wdg_irq)); // R8

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_irq
        AST_IRQ_PPI: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_lines[EXT_N + c*PPI_PER_CORE + PPI_TIMER] == tmr_irq[c]) &&
            (irq_lines[EXT_N + c*PPI_PER_CORE + PPI_WDOG]  == wdg_irq[c])); // R8
    end
endmodule

bind priv_win_top priv_win_chk #(
    .NUM_CORES (NUM_CORES),
    .IRQ_TOTAL (IRQ_TOTAL),
    .DATA_W    (DATA_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .ctl_sel   (ctl_sel),
    .cpuif_sel (cpuif_sel),
    .tmr_sel   (tmr_sel),
    .wdg_sel   (wdg_sel),
    .dist_sel  (dist_sel),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .ext_irq   (ext_irq),
    .tmr_irq   (tmr_irq),
    .wdg_irq   (wdg_irq),
    .irq_lines (irq_lines)
);

// File: tb/priv_win_top_tb_top.sv
module priv_win_top_tb_top;
    localparam int NC   = 3;
    localparam int IRQT = 64;
    localparam int DW   = 32;
    localparam int EXT  = IRQT - 32;
    localparam int LW   = EXT + 32 * NC;
    localparam int SELW = 3 * NC + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0] req_core = '0;
    logic ctl_sel, dist_sel, tgt_write, rsp_valid, rsp_err;
    logic [NC-1:0] cpuif_sel, tmr_sel, wdg_sel;
    logic [11:0] tgt_offset;
    logic [DW-1:0] tgt_wdata, rsp_rdata, ctl_rdata, dist_rdata;
    logic [NC*DW-1:0] cpuif_rdata, tmr_rdata, wdg_rdata;
    logic [EXT-1:0] ext_irq = '0;
    logic [NC-1:0] tmr_irq = '0, wdg_irq = '0;
    logic [LW-1:0] irq_lines;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    priv_win_top #(.NUM_CORES(NC), .IRQ_TOTAL(IRQT), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_core(req_core),
        .ctl_sel(ctl_sel), .cpuif_sel(cpuif_sel), .tmr_sel(tmr_sel), .wdg_sel(wdg_sel),
        .dist_sel(dist_sel), .tgt_write(tgt_write), .tgt_offset(tgt_offset),
        .tgt_wdata(tgt_wdata), .ctl_rdata(ctl_rdata), .cpuif_rdata(cpuif_rdata),
        .tmr_rdata(tmr_rdata), .wdg_rdata(wdg_rdata), .dist_rdata(dist_rdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .ext_irq(ext_irq), .tmr_irq(tmr_irq), .wdg_irq(wdg_irq), .irq_lines(irq_lines)
    );

    // Target models: upper bits name the target kind and core, low bits echo the offset
    always_comb begin
        ctl_rdata  = 32'hC000_0000 | 32'(tgt_offset);
        dist_rdata = 32'hE000_0000 | 32'(tgt_offset);
        for (int i = 0; i < NC; i++) begin
            cpuif_rdata[i*DW +: DW] = 32'hA000_0000 | (32'(i) << 16) | 32'(tgt_offset);
            tmr_rdata[i*DW +: DW]   = 32'hB000_0000 | (32'(i) << 16) | 32'(tgt_offset);
            wdg_rdata[i*DW +: DW]   = 32'hD000_0000 | (32'(i) << 16) | 32'(tgt_offset);
        end
    end

    typedef struct {
        logic [SELW-1:0] sel;
        logic [11:0]     off;
        logic            wr;
        logic [DW-1:0]   wd;
        logic            err;
        logic [DW-1:0]   rd;
        string           tag;
    } exp_t;

    exp_t sb_q[$];

    // Expected result from the address map; sel bit 0 ctl, 1+n cpuif, 1+NC+n timer, 1+2NC+n watchdog, top dist
    function automatic exp_t model(input logic [12:0] a, input logic [1:0] c,
                                   input logic wr, input logic [DW-1:0] wd, input string tag);
        exp_t e;
        int slot = int'(a[11:8]);
        int core;
        logic [DW-1:0] v = '0;
        e.sel = '0; e.off = '0; e.wr = wr; e.wd = wd; e.err = 1'b0; e.tag = tag;
        if (a[12]) begin
            e.sel[SELW-1] = 1'b1; e.off = a[11:0]; v = 32'hE000_0000 | 32'(a[11:0]);
        end else if (slot == 0) begin
            e.sel[0] = 1'b1; e.off = {4'd0, a[7:0]}; v = 32'hC000_0000 | 32'(a[7:0]);
        end else if (slot <= 5) begin
            core = (slot == 1) ? int'(c) : slot - 2;
            if (core < NC) begin
                e.sel[1+core] = 1'b1; e.off = {4'd0, a[7:0]};
                v = 32'hA000_0000 | (32'(core) << 16) | 32'(a[7:0]);
            end else e.err = 1'b1;
        end else if (slot <= 10) begin
            core = (slot == 6) ? int'(c) : slot - 7;
            e.off = {7'd0, a[4:0]};
            if (core >= NC || a[7:0] >= 8'h40) e.err = 1'b1;
            else if (a[7:0] < 8'h20) begin
                e.sel[1+NC+core] = 1'b1; v = 32'hB000_0000 | (32'(core) << 16) | 32'(a[4:0]);
            end else begin
                e.sel[1+2*NC+core] = 1'b1; v = 32'hD000_0000 | (32'(core) << 16) | 32'(a[4:0]);
            end
        end else e.err = 1'b1;
        e.rd = (e.err || wr) ? '0 : v;
        return e;
    endfunction

    task automatic send(input logic [12:0] a, input logic [1:0] c, input logic wr,
                        input logic [DW-1:0] wd, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_core = c; req_write = wr; req_wdata = wd;
        sb_q.push_back(model(a, c, wr, wd, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0; req_write = 1'b0;
        end
    endtask

    // Monitor: selects seen one negedge earlier pair with the response seen now
    logic [SELW-1:0] p_sel = '0;
    logic [11:0] p_off = '0;
    logic p_wr = 1'b0;
    logic [DW-1:0] p_wd = '0;

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            exp_t e;
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R7 unexpected response: act err=%0b rd=%h exp none", rsp_err, rsp_rdata);
            end else begin
                e = sb_q.pop_front();
                checks++;
                if (e.err ? (p_sel != '0)
                          : (p_sel != e.sel || p_off != e.off || p_wr != e.wr || p_wd != e.wd)) begin
                    errors++;
                    $display("FAIL %s target: act sel=%b off=%h wr=%0b wd=%h exp sel=%b off=%h wr=%0b wd=%h",
                             e.tag, p_sel, p_off, p_wr, p_wd, e.sel, e.off, e.wr, e.wd);
                end
                checks++;
                if (rsp_err != e.err || rsp_rdata != e.rd) begin
                    errors++;
                    $display("FAIL %s response: act err=%0b rd=%h exp err=%0b rd=%h",
                             e.tag, rsp_err, rsp_rdata, e.err, e.rd);
                end
            end
        end
        p_sel = {dist_sel, wdg_sel, tmr_sel, cpuif_sel, ctl_sel};
        p_off = tgt_offset; p_wr = tgt_write; p_wd = tgt_wdata;
    end

    task automatic irq_check(input logic [EXT-1:0] ex, input logic [NC-1:0] t, input logic [NC-1:0] w);
        logic [LW-1:0] exp_l;
        @(negedge clk);
        ext_irq = ex; tmr_irq = t; wdg_irq = w;
        #1;
        exp_l = '0;
        exp_l[EXT-1:0] = ex;
        for (int i = 0; i < NC; i++) begin
            exp_l[EXT + 32*i + 29] = t[i];
            exp_l[EXT + 32*i + 30] = w[i];
        end
        checks++;
        if (irq_lines !== exp_l) begin
            errors++;
            $display("FAIL R8 irq_lines: act %h exp %h", irq_lines, exp_l);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if ({ctl_sel, cpuif_sel, tmr_sel, wdg_sel, dist_sel} != '0 || rsp_valid) begin
            errors++;
            $display("FAIL R9 reset: act sel=%b rsp_valid=%0b exp sel=0 rsp_valid=0",
                     {ctl_sel, cpuif_sel, tmr_sel, wdg_sel, dist_sel}, rsp_valid);
        end
        rst_n = 1'b1;
        idle(2);
        send(13'h000, 2'd0, 1'b0, '0, "R1");
        send(13'h0FC, 2'd2, 1'b0, '0, "R1");
        send(13'h100, 2'd1, 1'b0, '0, "R2");
        send(13'h1A4, 2'd2, 1'b0, '0, "R2");
        send(13'h200, 2'd2, 1'b0, '0, "R2");
        send(13'h3F0, 2'd0, 1'b0, '0, "R2");
        send(13'h404, 2'd1, 1'b0, '0, "R2");
        idle(1);
        send(13'h600, 2'd0, 1'b0, '0, "R3");
        send(13'h61C, 2'd2, 1'b0, '0, "R3");
        send(13'h704, 2'd1, 1'b0, '0, "R3");
        send(13'h908, 2'd0, 1'b0, '0, "R3");
        send(13'h620, 2'd1, 1'b0, '0, "R4");
        send(13'h73C, 2'd2, 1'b0, '0, "R4");
        send(13'h820, 2'd0, 1'b0, '0, "R4");
        send(13'h1000, 2'd0, 1'b0, '0, "R5");
        send(13'h1FFC, 2'd1, 1'b0, '0, "R5");
        send(13'h500, 2'd0, 1'b0, '0, "R6");
        send(13'hA00, 2'd0, 1'b0, '0, "R6");
        send(13'h640, 2'd0, 1'b0, '0, "R6");
        send(13'h7E0, 2'd0, 1'b0, '0, "R6");
        send(13'hB00, 2'd0, 1'b0, '0, "R6");
        send(13'hFFC, 2'd0, 1'b0, '0, "R6");
        send(13'h104, 2'd3, 1'b0, '0, "R6");
        send(13'h624, 2'd3, 1'b0, '0, "R6");
        idle(2);
        send(13'h010, 2'd0, 1'b1, 32'h1234_5678, "R11");
        send(13'h228, 2'd0, 1'b1, 32'hCAFE_0001, "R11");
        send(13'h824, 2'd0, 1'b1, 32'h0BAD_F00D, "R11");
        send(13'h1040, 2'd2, 1'b0, '0, "R11");
        send(13'hC00, 2'd0, 1'b1, 32'hFFFF_FFFF, "R6");
        idle(4);
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R7 missing responses: act pending=%0d exp 0", sb_q.size());
        end
        irq_check(32'h8000_0001, 3'b101, 3'b010);
        irq_check(32'h0000_0000, 3'b010, 3'b111);
        irq_check(32'h5A5A_A5A5, 3'b000, 3'b000);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: act timeout exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule